// File: doc/BRIEF.md
# Variable-Precision Signed Multiplier with Slice Sleep

This unit multiplies two signed operands whose width a per-operation mode code selects among 16, 24 and 48 bits. Short 16-bit products come out of a single-cycle radix-4 Booth-recoded array. Wider products are built by a shift-add engine that retires one multiplier bit per enabled cycle. That engine is split into two 24-bit datapath slices. The upper slice (A) serves 24-bit work alone. For 48-bit work the upper slice carries the high halves of the operands and the lower slice (B) carries the low halves, with carry and shift bits passed between them every cycle.

A caller drives the operands and the mode code, then pulses `start`. It waits for a one-cycle `done` and reads `product`, which is always 96 bits wide and sign-extended for the narrower modes. While a serial operation runs, `busy` is high and further starts are ignored. An enable input freezes every register in the unit. Two sleep outputs tell the surrounding logic which slice is idle, so that its supply or clock can be cut.

Top module: `vpmul_top`

## Requirements
- R1: The mode code selects the word length: 2'b00 is 16 bits (operands `op_a[15:0]`, `op_b[15:0]`), 2'b01 is 24 bits (`[23:0]`), 2'b10 is 48 bits (`[47:0]`). A start with code 2'b11 is ignored: `busy` and `done` stay low and `product` is unchanged.
- R2: In 16-bit mode, `product` is the signed 32-bit product sign-extended to 96 bits. It appears together with `done` in the cycle after the start cycle, and `busy` is not raised.
- R3: In 24-bit mode, `product` is the signed 48-bit product sign-extended to 96 bits. `done` rises 25 cycles after the start cycle (one load cycle plus 24 bit cycles), and `busy` is high in between.
- R4: In 48-bit mode, `product` is the full signed 96-bit product. `done` rises 49 cycles after the start cycle.
- R5: `done` is high for exactly one cycle per accepted operation, and `busy` is low whenever `done` is high.
- R6: A start that arrives while `busy` is high is ignored. The running operation finishes at its original time with its original result.
- R7: `sleep_b` is low only while an enabled 48-bit operation runs. `sleep_a` is low only while an enabled 24-bit or 48-bit operation runs. Both are high when the unit is idle or doing 16-bit work.
- R8: While `en` is low, no register changes: a start is not accepted, a running operation stalls and resumes later, the completion time shifts by the number of disabled cycles, `done` reads low, both sleep outputs read high, and `product` holds its value.
- R9: After a synchronous reset, `product` is zero, `busy` and `done` are low, and both sleep outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Unit enable; low freezes every register |
| start | input | 1 | Begin an operation with the present operands and mode |
| mode | input | 2 | Word-length code: 00 16-bit, 01 24-bit, 10 48-bit, 11 reserved |
| op_a | input | 48 | Signed multiplicand (low bits used in narrow modes) |
| op_b | input | 48 | Signed multiplier (low bits used in narrow modes) |
| busy | output | 1 | Serial operation in progress |
| done | output | 1 | One-cycle completion strobe |
| product | output | 96 | Signed product, sign-extended in narrow modes |
| sleep_a | output | 1 | Upper slice idle |
| sleep_b | output | 1 | Lower slice idle |

## Verification
The bench builds the unit with its default parameters: 24-bit slices, which gives 48-bit wide operands, and a 16-bit Booth array. At these widths every mode, both slice roles, and the carry and shift links between the slices are exercised at their real sizes. Random operands in each mode are mixed with the extreme values: the most negative value squared, zero, and minus one times a positive number. Every cycle of each run is counted so that completion time can be compared exactly. Directed runs drop the enable in the middle of a serial operation, pulse a second start while busy, and issue the reserved mode code.

// File: rtl/vpmul_pkg.sv
package vpmul_pkg;

    typedef enum logic [1:0] {
        MODE_W16 = 2'b00,
        MODE_W24 = 2'b01,
        MODE_W48 = 2'b10,
        MODE_RSV = 2'b11
    } wl_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ctl_state_e;

    // Selection for one radix-4 Booth digit
    typedef struct packed {
        logic zero;
        logic dbl;
        logic neg;
    } booth_sel_t;

    // Bits {b[2i+1], b[2i], b[2i-1]} map to a digit in -2..+2
    function automatic booth_sel_t booth_decode(input logic [2:0] trip);
        booth_sel_t s;
        s = '{zero: 1'b0, dbl: 1'b0, neg: 1'b0};
        unique case (trip)
            3'b000, 3'b111: s.zero = 1'b1;
            3'b001, 3'b010: s.neg  = 1'b0;
            3'b011:         s.dbl  = 1'b1;
            3'b100: begin s.dbl = 1'b1; s.neg = 1'b1; end
            default:        s.neg  = 1'b1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/vpmul_booth.sv
module vpmul_booth
    import vpmul_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    localparam int PW  = 2 * W;
    localparam int NPP = W / 2;

    // Multiplier with an implicit zero below its LSB
    logic [W:0] bx;
    assign bx = {b, 1'b0};

    always_comb begin
        logic signed [PW-1:0] mcand;
        logic signed [PW-1:0] pp;
        logic signed [PW-1:0] acc;
        booth_sel_t           sel;
        mcand = PW'($signed(a));
        acc   = '0;
        for (int i = 0; i < NPP; i++) begin
            sel = booth_decode(bx[2*i +: 3]);
            if (sel.zero)
                pp = '0;
            else if (sel.dbl)
                pp = mcand <<< 1;
            else
                pp = mcand;
            if (sel.neg)
                pp = -pp;
            acc = acc + (pp <<< (2 * i));
        end
        p = acc;
    end

endmodule

// File: rtl/vpmul_slice.sv
module vpmul_slice #(
    parameter int W   = 24,
    parameter bit TOP = 1'b0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load,
    input  logic                        step,
    input  logic [W-1:0]                mc_ld,
    input  logic [W-1:0]                mq_ld,
    input  logic                        add_en,
    input  logic                        sub,
    input  logic                        cin,
    input  logic                        acc_msb_in,
    input  logic                        mq_msb_in,
    output logic                        cout,
    output logic                        sum_lsb,
    output logic                        sum_msb,
    output logic                        mq_lsb,
    output logic [(TOP ? W+1 : W)-1:0]  acc_nx,
    output logic [W-1:0]                mq_nx
);
    // The top slice carries one guard bit for the sign
    localparam int AW = TOP ? W + 1 : W;

    logic [W-1:0]  mc_r;
    logic [W-1:0]  mq_r;
    logic [AW-1:0] acc_r;
    logic [AW-1:0] mc_ext;
    logic [AW-1:0] addend;
    logic [AW-1:0] sum;

    generate
        if (TOP) begin : g_guard
            assign mc_ext = {mc_r[W-1], mc_r};
        end else begin : g_plain
            assign mc_ext = mc_r;
        end
    endgenerate

    assign addend         = add_en ? (sub ? ~mc_ext : mc_ext) : '0;
    assign {cout, sum}    = {1'b0, acc_r} + {1'b0, addend} + (AW+1)'(cin);
    assign sum_lsb        = sum[0];
    assign sum_msb        = sum[AW-1];
    assign mq_lsb         = mq_r[0];
    assign acc_nx         = {acc_msb_in, sum[AW-1:1]};
    assign mq_nx          = {mq_msb_in, mq_r[W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            mc_r  <= '0;
            mq_r  <= '0;
            acc_r <= '0;
        end else if (load) begin
            mc_r  <= mc_ld;
            mq_r  <= mq_ld;
            acc_r <= '0;
        end else if (step) begin
            acc_r <= acc_nx;
            mq_r  <= mq_nx;
        end
    end

endmodule

// File: rtl/vpmul_ctrl.sv
module vpmul_ctrl
    import vpmul_pkg::*;
#(
    parameter int SW = 24
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     start,
    input  wl_mode_e mode,
    output logic     busy,
    output logic     accept_booth,
    output logic     accept_ser,
    output logic     load_b,
    output logic     step,
    output logic     step_b,
    output logic     last,
    output logic     mode48
);
    localparam int FW = 2 * SW;
    localparam int CW = $clog2(FW);

    ctl_state_e    state;
    logic [CW-1:0] cnt;
    logic          m48_q;
    logic          accept_any;

    assign accept_any   = en & start & (state == ST_IDLE);
    assign accept_booth = accept_any & (mode == MODE_W16);
    assign accept_ser   = accept_any & ((mode == MODE_W24) | (mode == MODE_W48));
    assign load_b       = accept_ser & (mode == MODE_W48);
    assign busy         = (state == ST_RUN);
    assign step         = en & busy;
    assign step_b       = step & m48_q;
    assign last         = step & (cnt == '0);
    assign mode48       = m48_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            m48_q <= 1'b0;
        end else if (en) begin
            if (accept_ser) begin
                state <= ST_RUN;
                m48_q <= (mode == MODE_W48);
                cnt   <= (mode == MODE_W48) ? CW'(FW - 1) : CW'(SW - 1);
            end else if (state == ST_RUN) begin
                if (cnt == '0)
                    state <= ST_IDLE;
                else
                    cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/vpmul_top.sv
module vpmul_top
    import vpmul_pkg::*;
#(
    parameter int SW = 24,
    parameter int BW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [2*SW-1:0]   op_a,
    input  logic [2*SW-1:0]   op_b,
    output logic              busy,
    output logic              done,
    output logic [4*SW-1:0]   product,
    output logic              sleep_a,
    output logic              sleep_b
);
    localparam int FW = 2 * SW;
    localparam int PW = 2 * FW;

    wl_mode_e mode_e;
    logic accept_booth, accept_ser, load_b, step, step_b, last, mode48;
    logic done_q;

    assign mode_e = wl_mode_e'(mode);

    vpmul_ctrl #(.SW(SW)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .en           (en),
        .start        (start),
        .mode         (mode_e),
        .busy         (busy),
        .accept_booth (accept_booth),
        .accept_ser   (accept_ser),
        .load_b       (load_b),
        .step         (step),
        .step_b       (step_b),
        .last         (last),
        .mode48       (mode48)
    );

    // Short products
    logic [2*BW-1:0] booth_p;

    vpmul_booth #(.W(BW)) u_booth (
        .a (op_a[BW-1:0]),
        .b (op_b[BW-1:0]),
        .p (booth_p)
    );

    // Serial slices: A is the upper (or sole) slice, B the lower
    logic          cout_a, cout_b;
    logic          sum_lsb_a, sum_lsb_b, sum_msb_a, sum_msb_b;
    logic          mq_lsb_a, mq_lsb_b;
    logic [SW:0]   acc_nx_a;
    logic [SW-1:0] acc_nx_b, mq_nx_a, mq_nx_b;
    logic          bit_cur, cin_a, cin_b, mq_in_a;
    logic [SW-1:0] mc_ld_a, mq_ld_a;
    logic          wide_in;

    assign wide_in = (mode_e == MODE_W48);
    assign mc_ld_a = wide_in ? op_a[FW-1:SW] : op_a[SW-1:0];
    assign mq_ld_a = wide_in ? op_b[FW-1:SW] : op_b[SW-1:0];

    assign bit_cur = mode48 ? mq_lsb_b : mq_lsb_a;
    assign cin_b   = bit_cur & last;
    assign cin_a   = mode48 ? cout_b : (bit_cur & last);
    assign mq_in_a = mode48 ? sum_lsb_b : sum_lsb_a;

    vpmul_slice #(.W(SW), .TOP(1'b1)) u_slice_a (
        .clk        (clk),
        .rst        (rst),
        .load       (accept_ser),
        .step       (step),
        .mc_ld      (mc_ld_a),
        .mq_ld      (mq_ld_a),
        .add_en     (bit_cur),
        .sub        (last),
        .cin        (cin_a),
        .acc_msb_in (sum_msb_a),
        .mq_msb_in  (mq_in_a),
        .cout       (cout_a),
        .sum_lsb    (sum_lsb_a),
        .sum_msb    (sum_msb_a),
        .mq_lsb     (mq_lsb_a),
        .acc_nx     (acc_nx_a),
        .mq_nx      (mq_nx_a)
    );

    vpmul_slice #(.W(SW), .TOP(1'b0)) u_slice_b (
        .clk        (clk),
        .rst        (rst),
        .load       (load_b),
        .step       (step_b),
        .mc_ld      (op_a[SW-1:0]),
        .mq_ld      (op_b[SW-1:0]),
        .add_en     (bit_cur),
        .sub        (last),
        .cin        (cin_b),
        .acc_msb_in (sum_lsb_a),
        .mq_msb_in  (mq_lsb_a),
        .cout       (cout_b),
        .sum_lsb    (sum_lsb_b),
        .sum_msb    (sum_msb_b),
        .mq_lsb     (mq_lsb_b),
        .acc_nx     (acc_nx_b),
        .mq_nx      (mq_nx_b)
    );

    logic unused_slice_bits;
    assign unused_slice_bits = ^{cout_a, sum_msb_b, acc_nx_a[SW]};

    logic [FW-1:0] p_mid;
    logic [PW-1:0] p_wide;
    assign p_mid  = {acc_nx_a[SW-1:0], mq_nx_a};
    assign p_wide = {acc_nx_a[SW-1:0], acc_nx_b, mq_nx_a, mq_nx_b};

    always_ff @(posedge clk) begin
        if (rst) begin
            product <= '0;
            done_q  <= 1'b0;
        end else if (en) begin
            done_q <= accept_booth | last;
            if (accept_booth)
                product <= PW'($signed(booth_p));
            else if (last)
                product <= mode48 ? p_wide : PW'($signed(p_mid));
        end
    end

    assign done    = done_q & en;
    assign sleep_a = ~(en & busy);
    assign sleep_b = ~(en & busy & mode48);

endmodule

// File: rtl/vpmul_chk.sv
module vpmul_chk #(
    parameter int PW = 96
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic          start,
    input logic [1:0]    mode,
    input logic          busy,
    input logic          done,
    input logic [PW-1:0] product,
    input logic          sleep_a,
    input logic          sleep_b
);

    a_r1_reserved_ignored: assert property (@(posedge clk) disable iff (rst)
        (en && start && !busy && mode == 2'b11) |=> (!busy && !done));

    a_r2_booth_next_cycle: assert property (@(posedge clk) disable iff (rst)
        (en && start && !busy && mode == 2'b00) |=> done);

    a_r5_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r6_product_steady_in_run: assert property (@(posedge clk) disable iff (rst)
        (busy && en) |=> (done || $stable(product)));

    a_r7_lower_implies_upper: assert property (@(posedge clk) disable iff (rst)
        !sleep_b |-> !sleep_a);

    a_r7_awake_only_busy: assert property (@(posedge clk) disable iff (rst)
        !sleep_a |-> (busy && en));

    a_r8_off_quiet: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!done && sleep_a && sleep_b));

    a_r8_off_holds_product: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(product));

endmodule

bind vpmul_top vpmul_chk #(.PW(4*SW)) u_vpmul_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .start   (start),
    .mode    (mode),
    .busy    (busy),
    .done    (done),
    .product (product),
    .sleep_a (sleep_a),
    .sleep_b (sleep_b)
);

// File: tb/tb_vpmul_top.sv
module tb_vpmul_top;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 24;
    localparam int FW = 2 * SW;
    localparam int PW = 2 * FW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b1;
    logic          start = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [FW-1:0] op_a = '0;
    logic [FW-1:0] op_b = '0;
    logic          busy, done, sleep_a, sleep_b;
    logic [PW-1:0] product;

    int n_checks = 0;
    int n_fail = 0;

    vpmul_top #(.SW(SW), .BW(16)) dut (
        .clk(clk), .rst(rst), .en(en), .start(start), .mode(mode),
        .op_a(op_a), .op_b(op_b), .busy(busy), .done(done),
        .product(product), .sleep_a(sleep_a), .sleep_b(sleep_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req,
                         input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] ref_mul(input logic [1:0] m,
                                              input logic [FW-1:0] a,
                                              input logic [FW-1:0] b);
        logic signed [PW-1:0] x, y;
        case (m)
            2'b00: begin x = PW'($signed(a[15:0])); y = PW'($signed(b[15:0])); end
            2'b01: begin x = PW'($signed(a[23:0])); y = PW'($signed(b[23:0])); end
            default: begin x = PW'($signed(a)); y = PW'($signed(b)); end
        endcase
        return x * y;
    endfunction

    function automatic int ref_lat(input logic [1:0] m);
        return (m == 2'b00) ? 1 : ((m == 2'b01) ? SW + 1 : FW + 1);
    endfunction

    // One operation; optional mid-run disable (R8) and start while busy (R6)
    task automatic do_op(input logic [1:0] m, input logic [FW-1:0] a,
                         input logic [FW-1:0] b, input int stall_at,
                         input int stall_len, input bit poke);
        logic [PW-1:0] exp_p, hold;
        int k, exp_lat;
        string tag;
        exp_p   = ref_mul(m, a, b);
        exp_lat = ref_lat(m) + stall_len;
        tag     = (m == 2'b00) ? "R2" : ((m == 2'b01) ? "R3" : "R4");
        @(negedge clk);
        mode = m; op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        while (done !== 1'b1 && k < 400) begin
            if (k == 2 && m != 2'b00) begin
                check(sleep_a == 1'b0 && busy == 1'b1, "R7 upper slice awake", {94'd0, busy, sleep_a}, 96'd2);
                check(sleep_b == (m != 2'b10), "R7 lower slice sleep", {95'd0, sleep_b}, {95'd0, (m != 2'b10)});
            end
            if (stall_len > 0 && k == stall_at) begin
                hold = product;
                en = 1'b0;
                for (int s = 0; s < stall_len; s++) begin
                    @(negedge clk);
                    k++;
                    check(done == 1'b0 && product == hold && sleep_a && sleep_b,
                          "R8 disabled unit frozen", product, hold);
                end
                en = 1'b1;
            end
            if (poke && k == 4) begin
                start = 1'b1; mode = 2'b00; op_a = ~a; op_b = a;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        check(k == exp_lat, poke ? "R6 latency with ignored start" : {tag, " latency"},
              PW'(k), PW'(exp_lat));
        check(product == exp_p, poke ? "R6 result with ignored start" : {tag, " product"},
              product, exp_p);
        check(busy == 1'b0, "R5 busy low at done", {95'd0, busy}, 96'd0);
        @(negedge clk);
        check(done == 1'b0, "R5 done single pulse", {95'd0, done}, 96'd0);
        check(sleep_a && sleep_b, "R7 idle slices sleep", {94'd0, sleep_a, sleep_b}, 96'd3);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [PW-1:0] p0;
        int seed;
        seed = 32'h5EED_1234;
        void'($urandom(seed));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9
        check(product == '0 && !busy && !done && sleep_a && sleep_b,
              "R9 reset state", product, '0);

        // Directed corner cases
        do_op(2'b00, 48'h8000, 48'h8000, 0, 0, 1'b0);
        do_op(2'b00, 48'hFFFF, 48'h7FFF, 0, 0, 1'b0);
        do_op(2'b01, 48'h80_0000, 48'h80_0000, 0, 0, 1'b0);
        do_op(2'b01, 48'hFF_FFFF, 48'h12_3456, 0, 0, 1'b0);
        do_op(2'b01, 48'h0, 48'hAB_CDEF, 0, 0, 1'b0);
        do_op(2'b10, 48'h8000_0000_0000, 48'h8000_0000_0000, 0, 0, 1'b0);
        do_op(2'b10, 48'hFFFF_FFFF_FFFF, 48'h7FFF_FFFF_FFFF, 0, 0, 1'b0);
        do_op(2'b10, 48'h0000_0100_0000, 48'hFFFF_FF00_0001, 0, 0, 1'b0);

        // R8: disable mid-run, R6: start while busy
        do_op(2'b01, 48'h3_1415, 48'hF2_7182, 10, 7, 1'b0);
        do_op(2'b10, 48'h9ABC_DEF0_1234, 48'h5678_9ABC_DEF0, 30, 5, 1'b0);
        do_op(2'b10, 48'h1111_2222_3333, 48'hC444_5555_6666, 0, 0, 1'b1);
        do_op(2'b01, 48'h7F_FFFF, 48'h80_0001, 0, 0, 1'b1);

        // R1: reserved code ignored
        p0 = product;
        @(negedge clk);
        mode = 2'b11; op_a = 48'h5; op_b = 48'h7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check(!busy && !done && product == p0, "R1 reserved mode ignored", product, p0);
            @(negedge clk);
        end

        // R8: start while disabled is not accepted
        en = 1'b0; mode = 2'b00; op_a = 48'h3; op_b = 48'h4; start = 1'b1;
        @(negedge clk);
        start = 1'b0; en = 1'b1;
        @(negedge clk);
        check(!done && !busy && product == p0, "R8 start while disabled", product, p0);

        // Random stimulus in all modes
        for (int i = 0; i < 12; i++) begin
            for (int m = 0; m < 3; m++) begin
                logic [FW-1:0] ra, rb;
                ra = {$urandom(), $urandom()};
                rb = {$urandom(), $urandom()};
                do_op(2'(m), ra, rb, 0, 0, 1'b0);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule